// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block gathers event flags for a serial bus controller and turns them into one interrupt line and two DMA request lines. Transfer logic raises flags with single-cycle set pulses. Software reads and writes a small register set through a simple host port. Reads return data one cycle after the request.

The first six status flags can each be enabled as interrupt sources. A vector register gives software a fast way to service them. Each read returns a code for the lowest pending enabled flag and clears that flag as a side effect.

A DMA control register can hand the receive-ready and transmit-ready flags to the DMA request lines instead. Turning DMA on for a direction forces that direction's interrupt enable off.

Register addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | status |
| 1 | enable |
| 2 | vector |
| 3 | DMA control |
| 4 | test |

Any other address reads as zero.

Top module: `intr_status_vector`

## Requirements
- R1: `irq_o` is a registered output. After every clock edge it equals the OR of (status[5:0] AND enable[5:0]), using the values that edge stored.
- R2: A read of address 2 returns a vector code. The code is 1 plus the index of the lowest bit set in (status[5:0] AND enable). That status bit is cleared at the same edge. When nothing is pending the code is 0 and no status bit changes.
- R3: A write to address 3 keeps only bit 15 (receive DMA on) and bit 7 (transmit DMA on). `rx_dma_req` is bit 15 AND status bit 3 (receive ready). `tx_dma_req` is bit 7 AND status bit 4 (transmit ready). Both are registered, like `irq_o`.
- R4: A write to address 3 with bit 15 set clears enable bit 3. A write to address 3 with bit 7 set clears enable bit 4. Other enable bits are unchanged.
- R5: A write to address 0 clears each status bit that is written with a one, but only within mask 0x0027 (bits 0, 1, 2 and 5). All other status bits are unchanged, including the ready flags in bits 3 and 4.
- R6: A read of address 0 returns the stored status flags, with bit 12 taken from the `bus_busy` input in the read cycle.
- R7: A write to address 4 with bit 11 set sets status bits 5:0 all to one.
- R8: A one on `evt_set[i]` sets status bit i, except bit 12, which is ignored. When a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: Reset is synchronous and active high. It clears status, enable, DMA control, test, read data and all three request outputs.
- R10: A write to address 1 stores bits 5:0 as the enable register. A read of address 1 returns them with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd`, held until the next read |
| evt_set | input | 16 | Per-flag set pulses from transfer logic |
| bus_busy | input | 1 | Live bus-busy indication, shown in status bit 12 |
| irq_o | output | 1 | Combined interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench drains several pending flags one vector read at a time. A picker that favoured the highest bit, or that ignored the enable mask, would return codes in the wrong order or a code for a masked flag. It also collides event pulses with software clears and vector reads on the same bit, where a design that let the clear win would lose an event. Status writes of all ones check that bits 3, 4 and 8 survive, which a design with the wrong mask would wipe. DMA writes check that an interrupt enable drops and that the request lines follow the ready flags in the same cycle as the register update, not one cycle late.

// File: rtl/isv_pkg.sv
package isv_pkg;
    localparam int STAT_W = 16;
    localparam int EN_W   = 6;
    localparam int VEC_W  = $clog2(EN_W + 1);

    typedef enum logic [2:0] {
        ADDR_STAT = 3'd0,
        ADDR_EN   = 3'd1,
        ADDR_VEC  = 3'd2,
        ADDR_DMA  = 3'd3,
        ADDR_TEST = 3'd4
    } reg_addr_e;

    localparam logic [STAT_W-1:0] W1C_MASK    = 16'h0027;
    localparam logic [STAT_W-1:0] HW_SET_MASK = 16'hEFFF;
    localparam logic [STAT_W-1:0] DMA_KEEP    = 16'h8080;
    localparam logic [STAT_W-1:0] TEST_KEEP   = 16'hF80F;

    localparam int RX_RDY_BIT = 3;
    localparam int TX_RDY_BIT = 4;
    localparam int BUSY_BIT   = 12;
    localparam int RX_DMA_BIT = 15;
    localparam int TX_DMA_BIT = 7;
    localparam int FORCE_BIT  = 11;

    typedef struct packed {
        logic irq;
        logic rx_req;
        logic tx_req;
    } req_out_t;

    function automatic logic [STAT_W-1:0] dma_enable_kill(input logic [STAT_W-1:0] wd);
        logic [STAT_W-1:0] k;
        k = '0;
        k[RX_RDY_BIT] = wd[RX_DMA_BIT];
        k[TX_RDY_BIT] = wd[TX_DMA_BIT];
        return k;
    endfunction
endpackage

// File: rtl/isv_vector_pick.sv
module isv_vector_pick #(
    parameter int W  = 6,
    parameter int VW = $clog2(W + 1)
) (
    input  logic [W-1:0]  pending,
    output logic [W-1:0]  onehot,
    output logic [VW-1:0] vec
);
    always_comb begin
        onehot = '0;
        vec    = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pending[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                vec       = VW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/isv_status_reg.sv
module isv_status_reg #(
    parameter int W       = 16,
    parameter int FORCE_N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    input  logic         force_low,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    localparam logic [W-1:0] FORCE_MASK = W'((1 << FORCE_N) - 1);

    always_comb begin
        stat_d = (stat_q & ~clr_v) | set_v;
        if (force_low) stat_d = stat_d | FORCE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    assert_force_low_R7: assert property (@(posedge clk) disable iff (rst)
        force_low |=> ((stat_q & FORCE_MASK) == FORCE_MASK));

    assert_only_cleared_fall_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_v)) == '0));
endmodule

// File: rtl/isv_out_stage.sv
module isv_out_stage
    import isv_pkg::*;
#(
    parameter int W = STAT_W,
    parameter int E = EN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat_d,
    input  logic [E-1:0] en_d,
    input  logic [W-1:0] dma_d,
    output req_out_t     req_q
);
    req_out_t req_d;

    always_comb begin
        req_d.irq    = |(stat_d[E-1:0] & en_d);
        req_d.rx_req = dma_d[RX_DMA_BIT] & stat_d[RX_RDY_BIT];
        req_d.tx_req = dma_d[TX_DMA_BIT] & stat_d[TX_RDY_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end
endmodule

// File: rtl/intr_status_vector.sv
module intr_status_vector
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              bus_busy,
    output logic              irq_o,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    logic [STAT_W-1:0] stat_q, stat_d, set_v, clr_v;
    logic [EN_W-1:0]   en_q, en_d, pick_hot;
    logic [VEC_W-1:0]  pick_vec;
    logic [STAT_W-1:0] dma_q, dma_d, test_q, test_d, rdata_d;
    logic              force_low, vec_rd;
    req_out_t          req_q;

    wire wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    wire wr_en   = reg_wr && (reg_addr == ADDR_EN);
    wire wr_dma  = reg_wr && (reg_addr == ADDR_DMA);
    wire wr_test = reg_wr && (reg_addr == ADDR_TEST);

    isv_vector_pick #(.W(EN_W), .VW(VEC_W)) u_pick (
        .pending(stat_q[EN_W-1:0] & en_q),
        .onehot (pick_hot),
        .vec    (pick_vec)
    );

    always_comb begin
        vec_rd    = reg_rd && (reg_addr == ADDR_VEC);
        set_v     = evt_set & HW_SET_MASK;
        force_low = wr_test && reg_wdata[FORCE_BIT];
        clr_v     = '0;
        if (wr_stat) clr_v = reg_wdata & W1C_MASK;
        if (vec_rd)  clr_v = clr_v | STAT_W'(pick_hot);
    end

    isv_status_reg #(.W(STAT_W), .FORCE_N(EN_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_v    (set_v),
        .clr_v    (clr_v),
        .force_low(force_low),
        .stat_q   (stat_q),
        .stat_d   (stat_d)
    );

    always_comb begin
        en_d   = en_q;
        dma_d  = dma_q;
        test_d = test_q;
        if (wr_en)   en_d = reg_wdata[EN_W-1:0];
        if (wr_dma) begin
            dma_d = reg_wdata & DMA_KEEP;
            en_d  = en_q & ~dma_enable_kill(reg_wdata)[EN_W-1:0];
        end
        if (wr_test) test_d = reg_wdata & TEST_KEEP;
    end

    always_comb begin
        rdata_d = reg_rdata;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_STAT: begin
                    rdata_d           = stat_q;
                    rdata_d[BUSY_BIT] = bus_busy;
                end
                ADDR_EN:   rdata_d = STAT_W'(en_q);
                ADDR_VEC:  rdata_d = STAT_W'(pick_vec);
                ADDR_DMA:  rdata_d = dma_q;
                ADDR_TEST: rdata_d = test_q;
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            dma_q     <= '0;
            test_q    <= '0;
            reg_rdata <= '0;
        end else begin
            en_q      <= en_d;
            dma_q     <= dma_d;
            test_q    <= test_d;
            reg_rdata <= rdata_d;
        end
    end

    isv_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .stat_d(stat_d),
        .en_d  (en_d),
        .dma_d (dma_d),
        .req_q (req_q)
    );

    assign irq_o      = req_q.irq;
    assign rx_dma_req = req_q.rx_req;
    assign tx_dma_req = req_q.tx_req;

    assert_irq_tracks_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |(stat_q[EN_W-1:0] & en_q)));

    assert_vec_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && pick_vec != '0 && !evt_set[pick_vec - 1'b1])
        |=> !stat_q[$past(pick_vec) - 1'b1]);

    assert_dma_drops_rx_ie_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && reg_wdata[RX_DMA_BIT]) |=> !en_q[RX_RDY_BIT]);

    assert_dma_drops_tx_ie_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && reg_wdata[TX_DMA_BIT]) |=> !en_q[TX_RDY_BIT]);

    assert_rx_req_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rx_dma_req == (dma_q[RX_DMA_BIT] && stat_q[RX_RDY_BIT])));

    assert_busy_never_stored_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !stat_q[BUSY_BIT]);
endmodule

// File: tb/test_intr_status_vector.sv
`timescale 1ns/1ps
module test_intr_status_vector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, evt_set = '0;
    logic        bus_busy = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_o, rx_dma_req, tx_dma_req;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_stat, m_dma, m_test, m_rd;
    logic [5:0]  m_en;
    logic        m_irq, m_rx, m_tx;

    always #2.5 clk = ~clk;

    intr_status_vector i_intr_status_vector (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .bus_busy(bus_busy), .irq_o(irq_o),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_stat = '0; m_dma = '0; m_test = '0; m_rd = '0; m_en = '0;
        m_irq = 0; m_rx = 0; m_tx = 0;
    endtask

    task automatic compare(input string tag);
        check("R1 irq", {15'd0, irq_o}, {15'd0, m_irq});
        check("R3 rx_req", {15'd0, rx_dma_req}, {15'd0, m_rx});
        check("R3 tx_req", {15'd0, tx_dma_req}, {15'd0, m_tx});
        check(tag, reg_rdata, m_rd);
    endtask

    task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                        input logic [15:0] wd, input logic [15:0] ev,
                        input logic busy, input string tag);
        logic [15:0] clr, set;
        logic [5:0]  pend;
        int          low;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        evt_set = ev; bus_busy = busy;
        @(posedge clk);
        pend = m_stat[5:0] & m_en;
        low = -1;
        for (int i = 5; i >= 0; i--) if (pend[i]) low = i;
        if (rd) begin
            case (a)
                3'd0: m_rd = m_stat | (busy ? 16'h1000 : 16'h0);
                3'd1: m_rd = {10'd0, m_en};
                3'd2: m_rd = (low < 0) ? 16'd0 : 16'(low + 1);
                3'd3: m_rd = m_dma;
                3'd4: m_rd = m_test;
                default: m_rd = '0;
            endcase
        end
        clr = '0;
        if (wr && a == 3'd0) clr = wd & 16'h0027;
        if (rd && a == 3'd2 && low >= 0) clr[low] = 1'b1;
        set = ev & 16'hEFFF;
        if (wr && a == 3'd4 && wd[11]) set = set | 16'h003F;
        m_stat = (m_stat & ~clr) | set;
        if (wr && a == 3'd1) m_en = wd[5:0];
        if (wr && a == 3'd3) begin
            m_dma = wd & 16'h8080;
            if (wd[15]) m_en[3] = 1'b0;
            if (wd[7])  m_en[4] = 1'b0;
        end
        if (wr && a == 3'd4) m_test = wd & 16'hF80F;
        m_irq = |(m_stat[5:0] & m_en);
        m_rx  = m_dma[15] & m_stat[3];
        m_tx  = m_dma[7] & m_stat[4];
        #1;
        compare(tag);
        reg_wr = 0; reg_rd = 0; evt_set = '0;
    endtask

    task automatic wr_(input logic [2:0] a, input logic [15:0] d, input string tag);
        step(1, 0, a, d, 16'h0, 0, tag);
    endtask
    task automatic rd_(input logic [2:0] a, input string tag);
        step(0, 1, a, 16'h0, 16'h0, 0, tag);
    endtask
    task automatic ev_(input logic [15:0] e, input string tag);
        step(0, 0, 3'd0, 16'h0, e, 0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare("R9 reset rdata");
        rst = 0;
        for (int a = 0; a < 6; a++) rd_(3'(a), "R9 reset regs");

        wr_(3'd1, 16'hFFFF, "R10");
        rd_(3'd1, "R10 enable readback");
        ev_(16'h0004, "R1 event raises irq");
        ev_(16'h0026, "R2 setup");
        rd_(3'd2, "R2 vector lowest");
        rd_(3'd2, "R2 vector next");
        rd_(3'd2, "R2 vector last");
        rd_(3'd2, "R2 vector empty");
        rd_(3'd0, "R2 status after drain");

        wr_(3'd1, 16'h0020, "R2 mask setup");
        ev_(16'h0021, "R2 setup masked");
        rd_(3'd2, "R2 vector skips masked bit");
        wr_(3'd0, 16'h0001, "R5 clear bit0");

        ev_(16'h1118, "R8 busy bit ignored");
        wr_(3'd0, 16'hFFFF, "R5 w1c");
        rd_(3'd0, "R5 ready flags kept");
        step(0, 1, 3'd0, 16'h0, 16'h0, 1, "R6 busy shown");
        rd_(3'd0, "R6 busy low");

        wr_(3'd1, 16'h003F, "R4 setup");
        wr_(3'd3, 16'hFFFF, "R3 dma keep");
        rd_(3'd3, "R3 dma readback");
        rd_(3'd1, "R4 both enables dropped");
        wr_(3'd1, 16'h003F, "R4 setup2");
        wr_(3'd3, 16'h8000, "R4 rx only");
        rd_(3'd1, "R4 rx enable dropped");
        wr_(3'd0, 16'h0027, "R3 clear");
        wr_(3'd3, 16'h0080, "R4 tx only");
        rd_(3'd1, "R4 tx enable dropped");

        wr_(3'd0, 16'hFFFF, "R7 setup");
        wr_(3'd4, 16'h0800, "R7 force");
        rd_(3'd0, "R7 forced bits");
        rd_(3'd4, "R7 test readback");

        wr_(3'd1, 16'h003F, "R8 setup");
        step(1, 0, 3'd0, 16'h0001, 16'h0001, 0, "R8 set beats w1c");
        rd_(3'd0, "R8 bit0 kept");
        step(0, 1, 3'd2, 16'h0, 16'h0001, 0, "R8 set beats vector clear");
        rd_(3'd0, "R8 bit0 kept after vector");

        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: step(1, 0, 3'($urandom_range(0, 5)), 16'($urandom), 16'h0,
                        1'($urandom), "R2 random write");
                1: step(0, 1, 3'($urandom_range(0, 5)), 16'h0, 16'($urandom) & 16'h0018,
                        1'($urandom), "R2 random read");
                default: step(0, 0, 3'd0, 16'h0, 16'($urandom) & 16'h113F,
                              1'($urandom), "R8 random events");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule